// File: doc/BRIEF.md
# Dual-Slot Instruction Retirement Controller

This block decides, every cycle, how many instructions leave the head of an in-order completion queue. It can retire none, only the oldest entry (slot 0), or the two oldest entries together (slots 0 and 1). The decision is combinational. It is computed from the registered status of the two head entries. Each entry's status holds a finished flag, an exception flag, a two-bit instruction class, a flag marking that the entry sits behind an unresolved predicted branch, and the number of writes it makes to the condition, general-purpose and floating-point register files. The retire strobes drive a shift output that pops the queue by the number of entries retired.

A small completion FIFO model is included so the decision logic can be driven. Entries enter through a valid/ready stream, one per cycle. The back-pressure rules are simple. `in_ready` is high whenever fewer than DEPTH entries are stored. A push completes on a rising edge where both `in_valid` and `in_ready` are high. A pop in the same cycle does not raise `in_ready`. A separate mark port, addressed by storage slot, lets execution units flag an entry as finished and optionally as faulting.

When the oldest entry is finished but faulting, nothing retires and an exception request is raised instead. Handling that exception lies outside this block.

Top module: `dual_retire_ctrl`

## Requirements
- R1: Slot 0 retires when the queue holds an entry that is finished and has no exception. `rt_shift` always equals the number of strobes raised (0, 1 or 2).
- R2: When the oldest entry is finished and carries an exception, `rt_slot0`, `rt_slot1` and `rt_shift` are 0 and `exc_req` is 1. Otherwise `exc_req` is 0.
- R3: Slot 1 never retires in a cycle in which slot 0 does not retire.
- R4: Slot 1 retires only if the second entry is finished.
- R5: Slot 1 does not retire while the second entry's unresolved-branch flag is set.
- R6: Slot 1 does not retire while the second entry's exception flag is set.
- R7: Class codes are 0 integer, 1 load, 2 store and 3 other. Slot 1 may retire only with class 0 or 1. Slot 0 retires regardless of class.
- R8: Slot 1 retires only if, for each of the condition, general-purpose and floating-point register files separately, the sum of both entries' write counts is at most 2.
- R9: After reset the queue is empty, nothing retires and `in_ready` is 1. `in_ready` is 0 when DEPTH entries are stored. Entries retire in push order, and the queue is popped by `rt_shift`.
- R10: A mark on `mk_slot` sets that entry's finished flag and ORs `mk_exc` into its exception flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New entry offered |
| in_ready | output | 1 | Queue can accept an entry |
| in_fin | input | 1 | Entry already finished at dispatch |
| in_exc | input | 1 | Entry already faulting at dispatch |
| in_cls | input | 2 | Class: 0 int, 1 load, 2 store, 3 other |
| in_spec | input | 1 | Entry follows an unresolved predicted branch |
| in_crw | input | 2 | Condition-register write count |
| in_gprw | input | 2 | General-register write count |
| in_fprw | input | 2 | Floating-register write count |
| mk_valid | input | 1 | Mark an entry finished |
| mk_slot | input | $clog2(DEPTH) | Storage slot to mark |
| mk_exc | input | 1 | Mark also flags an exception |
| rt_slot0 | output | 1 | Oldest entry retires |
| rt_slot1 | output | 1 | Second entry retires |
| rt_shift | output | 2 | Queue pop amount |
| exc_req | output | 1 | Oldest entry faults; retirement held |

## Verification
A table of head-pair patterns starts from a standard pair that retires both entries. Each row then changes one attribute of the second entry: finished, branch flag, exception, class, or one register file's write count. That isolates which gate blocks the dual retirement. Count rows sit at exactly two and at three, so a wrong comparison bound shows up. Directed runs use a full queue, back-to-back retirement of mixed classes to confirm in-order popping, and marks applied out of order to confirm that slot 1 waits for slot 0.

// File: rtl/dret_pkg.sv
package dret_pkg;
  localparam int WCNT_W = 2;
  localparam int WR_CAP = 2;

  typedef enum logic [1:0] {
    CLS_INT   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_OTHER = 2'd3
  } iclass_e;

  typedef struct packed {
    logic              fin;
    logic              exc;
    iclass_e           cls;
    logic              spec;
    logic [WCNT_W-1:0] crw;
    logic [WCNT_W-1:0] gprw;
    logic [WCNT_W-1:0] fprw;
  } cq_entry_t;
endpackage

// File: rtl/dret_fifo.sv
module dret_fifo
  import dret_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  cq_entry_t       push_d,
  input  logic [1:0]      pop,
  input  logic            mk_valid,
  input  logic [AW-1:0]   mk_slot,
  input  logic            mk_exc,
  output cq_entry_t       head0,
  output cq_entry_t       head1,
  output logic            hv0,
  output logic            hv1,
  output logic            full
);
  cq_entry_t           mem [DEPTH];
  logic [AW-1:0]       rd_ptr, wr_ptr;
  logic [CNTW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (mk_valid) begin
        mem[mk_slot].fin <= 1'b1;
        mem[mk_slot].exc <= mem[mk_slot].exc | mk_exc;
      end
      if (push) mem[wr_ptr] <= push_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop);
      cnt    <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[rd_ptr + AW'(1)];
  assign hv0   = (cnt >= CNTW'(1));
  assign hv1   = (cnt >= CNTW'(2));
  assign full  = (cnt == CNTW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push); // R9
  AST_POP_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) CNTW'(pop) <= cnt); // R9
  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(cnt) == int'($past(cnt)) + int'($past(push)) - int'($past(pop))); // R9
endmodule

// File: rtl/dret_cap.sv
module dret_cap #(
  parameter int CW  = 2,
  parameter int CAP = 2
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic          ok
);
  logic [CW:0] sum;
  assign sum = {1'b0, a} + {1'b0, b};
  assign ok  = (sum <= (CW+1)'(CAP));
endmodule

// File: rtl/dret_pick.sv
module dret_pick
  import dret_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hv0,
  input  logic      hv1,
  input  logic      h0_fin,
  input  logic      h0_exc,
  input  logic [WCNT_W-1:0] h0_crw,
  input  logic [WCNT_W-1:0] h0_gprw,
  input  logic [WCNT_W-1:0] h0_fprw,
  input  cq_entry_t h1,
  output logic      ret0,
  output logic      ret1,
  output logic      exc_req,
  output logic [1:0] shift
);
  localparam int NFILE = 3;

  logic [NFILE-1:0][WCNT_W-1:0] cnt_a, cnt_b;
  logic [NFILE-1:0]             cap_ok;
  logic                         cls_ok;

  assign cnt_a = {h0_fprw, h0_gprw, h0_crw};
  assign cnt_b = {h1.fprw, h1.gprw, h1.crw};

  for (genvar g = 0; g < NFILE; g++) begin : g_cap
    dret_cap #(.CW(WCNT_W), .CAP(WR_CAP)) u_cap (
      .a  (cnt_a[g]),
      .b  (cnt_b[g]),
      .ok (cap_ok[g])
    );
  end

  always_comb begin
    unique case (h1.cls)
      CLS_INT, CLS_LOAD: cls_ok = 1'b1;
      default:           cls_ok = 1'b0;
    endcase
  end

  assign exc_req = hv0 & h0_fin & h0_exc;
  assign ret0    = hv0 & h0_fin & ~h0_exc;
  assign ret1    = ret0 & hv1 & h1.fin & ~h1.exc & ~h1.spec & cls_ok & (&cap_ok);
  assign shift   = 2'(ret0) + 2'(ret1);

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ret1 |-> ret0); // R3
  AST_EXC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) exc_req |-> (shift == 2'd0)); // R2
  AST_SLOT1_FIN: assert property (@(posedge clk) disable iff (!rst_n) ret1 |-> (h1.fin && !h1.exc && !h1.spec)); // R4
  AST_SLOT1_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    ret1 |-> (h1.cls == CLS_INT || h1.cls == CLS_LOAD)); // R7
  AST_WRITE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ret1 |-> ((int'(h0_crw) + int'(h1.crw) <= WR_CAP) && (int'(h0_gprw) + int'(h1.gprw) <= WR_CAP)
              && (int'(h0_fprw) + int'(h1.fprw) <= WR_CAP))); // R8
  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) shift != 2'd3); // R1
endmodule

// File: rtl/dual_retire_ctrl.sv
module dual_retire_ctrl
  import dret_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int SW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_fin,
  input  logic          in_exc,
  input  logic [1:0]    in_cls,
  input  logic          in_spec,
  input  logic [1:0]    in_crw,
  input  logic [1:0]    in_gprw,
  input  logic [1:0]    in_fprw,
  input  logic          mk_valid,
  input  logic [SW-1:0] mk_slot,
  input  logic          mk_exc,
  output logic          rt_slot0,
  output logic          rt_slot1,
  output logic [1:0]    rt_shift,
  output logic          exc_req
);
  cq_entry_t din, h0, h1;
  logic      hv0, hv1, full, push;

  assign din = '{fin: in_fin, exc: in_exc, cls: iclass_e'(in_cls), spec: in_spec,
                 crw: in_crw, gprw: in_gprw, fprw: in_fprw};
  assign in_ready = ~full;
  assign push     = in_valid & in_ready;

  dret_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_d   (din),
    .pop      (rt_shift),
    .mk_valid (mk_valid),
    .mk_slot  (mk_slot),
    .mk_exc   (mk_exc),
    .head0    (h0),
    .head1    (h1),
    .hv0      (hv0),
    .hv1      (hv1),
    .full     (full)
  );

  dret_pick u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .hv0     (hv0),
    .hv1     (hv1),
    .h0_fin  (h0.fin),
    .h0_exc  (h0.exc),
    .h0_crw  (h0.crw),
    .h0_gprw (h0.gprw),
    .h0_fprw (h0.fprw),
    .h1      (h1),
    .ret0    (rt_slot0),
    .ret1    (rt_slot1),
    .exc_req (exc_req),
    .shift   (rt_shift)
  );

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !hv0 |-> (rt_shift == 2'd0)); // R9
  AST_RETIRE_NEEDS_FIN: assert property (@(posedge clk) disable iff (!rst_n) rt_slot0 |-> h0.fin); // R1
endmodule

// File: tb/dual_retire_ctrl_test.sv
`timescale 1ns/1ps
module dual_retire_ctrl_test;
  localparam int DEPTH = 8;
  localparam int SW = $clog2(DEPTH);
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_fin = 1'b0, in_exc = 1'b0, in_spec = 1'b0;
  logic [1:0] in_cls = '0, in_crw = '0, in_gprw = '0, in_fprw = '0;
  logic mk_valid = 1'b0, mk_exc = 1'b0;
  logic [SW-1:0] mk_slot = '0;
  logic in_ready, rt_slot0, rt_slot1, exc_req;
  logic [1:0] rt_shift;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_retire_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fin(in_fin), .in_exc(in_exc), .in_cls(in_cls), .in_spec(in_spec),
    .in_crw(in_crw), .in_gprw(in_gprw), .in_fprw(in_fprw),
    .mk_valid(mk_valid), .mk_slot(mk_slot), .mk_exc(mk_exc),
    .rt_slot0(rt_slot0), .rt_slot1(rt_slot1), .rt_shift(rt_shift), .exc_req(exc_req)
  );

  // {a_exc, a_cr, a_gpr, a_fpr, b_fin, b_exc, b_cls, b_spec, b_cr, b_gpr, b_fpr, e0, e1, eexc}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b1,1'b0}, // R1 base pair
    {1'b0,2'd0,2'd1,2'd0, 1'b0,1'b0,2'd0,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R4
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd0,1'b1,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R5
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b1,2'd0,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R6
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd2,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R7 store
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd3,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R7 other
    {1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd1,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b1,1'b0}, // R7 load
    {1'b0,2'd0,2'd2,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd1,2'd0, 1'b1,1'b0,1'b0}, // R8 gpr 3
    {1'b0,2'd0,2'd2,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd0,2'd0, 1'b1,1'b1,1'b0}, // R8 gpr 2
    {1'b0,2'd1,2'd0,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd2,2'd0,2'd0, 1'b1,1'b0,1'b0}, // R8 cr 3
    {1'b0,2'd2,2'd0,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd0,2'd0, 1'b1,1'b1,1'b0}, // R8 cr 2
    {1'b0,2'd0,2'd0,2'd3, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd0,2'd0, 1'b1,1'b0,1'b0}, // R8 fpr 3
    {1'b0,2'd0,2'd0,2'd1, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd0,2'd1, 1'b1,1'b1,1'b0}, // R8 fpr 2
    {1'b1,2'd0,2'd1,2'd0, 1'b1,1'b0,2'd0,1'b0,2'd0,2'd1,2'd0, 1'b0,1'b0,1'b1}  // R2 faulting head
  };
  string tag [NV] = '{"R1", "R4", "R5", "R6", "R7", "R7", "R7", "R8", "R8", "R8", "R8", "R8", "R8", "R2"};

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_out(input string req, input int e0, input int e1, input int ex);
    check(req, "rt_slot0", int'(rt_slot0), e0);
    check(req, "rt_slot1", int'(rt_slot1), e1);
    check("R1", "rt_shift", int'(rt_shift), e0 + e1);
    check(req, "exc_req", int'(exc_req), ex);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    in_valid = 1'b0; mk_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push_e(input logic f, input logic e, input logic [1:0] c, input logic s,
                        input logic [1:0] cr, input logic [1:0] gp, input logic [1:0] fp);
    @(negedge clk);
    in_valid = 1'b1; in_fin = f; in_exc = e; in_cls = c; in_spec = s;
    in_crw = cr; in_gprw = gp; in_fprw = fp;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mark(input logic [SW-1:0] slot, input logic e);
    @(negedge clk);
    mk_valid = 1'b1; mk_slot = slot; mk_exc = e;
    @(negedge clk);
    mk_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  initial begin
    // R9 reset state
    do_reset();
    check("R9", "in_ready", int'(in_ready), 1);
    check_out("R9", 0, 0, 0);

    // Table walk: A and B pushed unfinished-head, then A marked
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      do_reset();
      push_e(1'b0, 1'b0, 2'd0, 1'b0, v[19:18], v[17:16], v[15:14]);
      push_e(v[13], v[12], v[11:10], v[9], v[8:7], v[6:5], v[4:3]);
      check_out("R3", 0, 0, 0); // head unfinished: second never goes alone
      mark('0, v[20]);
      check_out(tag[i], int'(v[2]), int'(v[1]), int'(v[0]));
    end

    // R1 single finished entry, then queue empty
    do_reset();
    push_e(1'b1, 1'b0, 2'd3, 1'b0, 2'd3, 2'd3, 2'd3);
    @(negedge clk);
    check_out("R9", 0, 0, 0); // already popped at the edge after the push became visible
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_fin = 1'b1; in_exc = 1'b0; in_cls = 2'd2; in_spec = 1'b0;
    in_crw = 2'd3; in_gprw = 2'd0; in_fprw = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R1", 1, 0, 0);
    @(negedge clk);
    check_out("R9", 0, 0, 0);

    // R9 full queue back-pressure
    do_reset();
    for (int k = 0; k < DEPTH; k++) push_e(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0);
    check("R9", "in_ready full", int'(in_ready), 0);
    push_e(1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0); // refused while full
    check_out("R9", 0, 0, 0);
    mark('0, 1'b0);
    check_out("R4", 1, 0, 0);
    @(negedge clk);
    check("R9", "in_ready after pop", int'(in_ready), 1);
    check_out("R9", 0, 0, 0); // refused push never entered the queue

    // R9 in-order popping across classes
    do_reset();
    push_e(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0);
    push_e(1'b1, 1'b0, 2'd1, 1'b0, 2'd0, 2'd1, 2'd0);
    push_e(1'b1, 1'b0, 2'd2, 1'b0, 2'd0, 2'd0, 2'd0);
    mark('0, 1'b0);
    check_out("R7", 1, 1, 0);
    @(negedge clk);
    check_out("R7", 1, 0, 0); // store at head retires from slot 0
    @(negedge clk);
    check_out("R9", 0, 0, 0);

    // R10 marks applied out of order, one with a fault
    do_reset();
    push_e(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0);
    push_e(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0);
    mark(SW'(1), 1'b1);
    check_out("R10", 0, 0, 0);
    mark('0, 1'b0);
    check_out("R10", 1, 0, 0);
    @(negedge clk);
    check_out("R10", 0, 0, 1); // faulting entry now at head
    @(negedge clk);
    check_out("R2", 0, 0, 1);

    finish_run();
  end
endmodule